// File: doc/BRIEF.md
# Delta Pattern Prefetch Detector

This block turns a short history of recent cache-line accesses into prefetch requests. A trigger carries the line address of a new unique access together with a window of up to sixteen older line addresses, each with a valid flag. The detector keeps only the addresses that share the trigger's 64 KB region, sorts them into ascending order and takes the differences between neighbours. Sorting first means that a stream reordered by out-of-order execution still shows its underlying stride.

Two predictors then examine the delta sequence. The generic predictor looks for the longest tail of the sequence that also appears earlier, and replays the deltas that followed that earlier copy, four steps beyond the highest binned address. The exponential predictor recognises a stride that roughly doubles at every step and projects only two steps. Each predicted line is compared against a small fully associative buffer of lines already requested. Repeats are dropped, and new lines are inserted as they leave the block. The work takes several cycles. A busy flag covers that time, and any trigger that arrives while it is high is ignored.

Top module: `delta_prefetch_detector`

## Requirements
- R1: Only addresses whose bits [25:10] equal those of the trigger take part, the trigger itself included. History entries with their valid flag low, or from another region, have no effect on the predictions.
- R2: The binned addresses are ordered ascending before deltas are formed, so their arrival order does not matter. Predictions are offsets from the highest binned address.
- R3: Fewer than four binned addresses (fewer than three deltas) produce no prefetch. Four addresses are enough.
- R4: Generic mode: among all earlier end positions, take the one with the longest matching tail of deltas, the most recent one on a tie. The deltas after it are replayed cyclically up to the newest delta, giving four cumulative prefetches. No prefetch comes from a sequence with no recurring delta unless R5 applies.
- R5: Exponential mode: the last three deltas d0, d1, d2 qualify when d0 is nonzero and each later delta lies within 2x-1 .. 2x+1 of the one before it. The predicted deltas are then 2*d2 and 4*d2, giving two prefetches. Generic mode wins when both modes match.
- R6: A predicted line outside the trigger's region is not issued, and neither is any later prediction of the same run.
- R7: A 32-entry collapsing buffer drops any prediction that it holds. Each issued line is inserted, overwriting the oldest entry once the buffer is full.
- R8: Prefetches leave on a valid/ready pair, at most one per cycle, in increasing distance. The address is held steady while ready is low.
- R9: busy is high from the cycle after an accepted trigger until the block returns to idle. Triggers seen while busy are ignored.
- R10: After reset, busy and the prefetch valid are low and the collapsing buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_valid | input | 1 | New unique access present |
| trig_addr | input | 26 | Line address of the new access |
| hist_addr | input | 416 | Sixteen older line addresses, entry i at bits [26*i+25:26*i] |
| hist_valid | input | 16 | Valid flag per history entry |
| busy | output | 1 | Detection in progress |
| pf_valid | output | 1 | Prefetch address offered |
| pf_ready | input | 1 | Consumer takes the prefetch address |
| pf_addr | output | 26 | Predicted line address |

## Verification
Eviction from the collapsing buffer is the hardest case to reach, because it depends on how many lines were issued since a given line went in. The bench runs one stride in a fresh region, then seven runs of four issued lines in other regions, and checks that repeating the first stride still collapses. One more run brings the count of later inserts to exactly thirty-two, after which the first stride's lines must be issued again. Out-of-order arrival, foreign-region entries and a pattern that satisfies both predictors are each built from chosen history windows.

// File: rtl/pf_pkg.sv
// Shared types of the delta pattern prefetch detector.
// Assumes nothing beyond a SystemVerilog 2017 compiler.
package pf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SORT,
        ST_DELTA,
        ST_MATCH,
        ST_ISSUE
    } pf_state_e;

    typedef enum logic [1:0] {
        MODE_NONE,
        MODE_GEN,
        MODE_EXP
    } pf_mode_e;
endpackage

// File: rtl/pf_sort_net.sv
// Odd-even transposition sorter over S keys of width W.
// Loads all keys in one cycle, then each step performs one compare-exchange
// pass over the even or odd neighbour pairs. S passes give a full ascending sort.
// Assumes the caller alternates the phase and counts the passes.
module pf_sort_net #(
    parameter int S = 17,
    parameter int W = 27
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [S*W-1:0] load_keys,
    input  logic           step,
    input  logic           odd,
    output logic [S*W-1:0] keys
);
    logic [W-1:0] k_q   [S];
    logic [W-1:0] k_nxt [S];

    // One compare-exchange pass over the pairs selected by the phase.
    always_comb begin
        for (int i = 0; i < S; i++) k_nxt[i] = k_q[i];
        for (int i = 0; i + 1 < S; i++) begin
            if (((i % 2) == int'(odd)) && (k_q[i] > k_q[i+1])) begin
                k_nxt[i]   = k_q[i+1];
                k_nxt[i+1] = k_q[i];
            end
        end
    end

    // Key storage: load, sort pass, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < S; i++) k_q[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < S; i++) k_q[i] <= load_keys[i*W +: W];
        end else if (step) begin
            for (int i = 0; i < S; i++) k_q[i] <= k_nxt[i];
        end
    end

    for (genvar g = 0; g < S; g++) begin : g_out
        assign keys[g*W +: W] = k_q[g];
    end
endmodule

// File: rtl/pf_suffix_match.sv
// Combinational tail matcher: counts how many deltas ending at position j
// equal the deltas ending at position last, walking backwards.
// Assumes j < last; entries below index 0 end the run.
module pf_suffix_match #(
    parameter int DP = 32,
    parameter int AW = 26,
    parameter int IW = 5
) (
    input  logic [DP*AW-1:0] deltas,
    input  logic [IW-1:0]    last_i,
    input  logic [IW-1:0]    j_i,
    output logic [IW-1:0]    len
);
    logic [AW-1:0] d [DP];

    for (genvar g = 0; g < DP; g++) begin : g_unpack
        assign d[g] = deltas[g*AW +: AW];
    end

    // Length of the matching run of deltas, newest first.
    always_comb begin
        logic run;
        logic [IW-1:0] ja;
        logic [IW-1:0] la;
        run = 1'b1;
        len = '0;
        for (int t = 0; t < DP; t++) begin
            ja = j_i - IW'(t);
            la = last_i - IW'(t);
            if (run && (t <= int'(j_i)) && (d[ja] == d[la])) len = len + 1'b1;
            else run = 1'b0;
        end
    end
endmodule

// File: rtl/pf_collapse_buf.sv
// Fully associative buffer of recently issued line addresses.
// Lookup is combinational; insertion writes the slot after the newest one,
// so the oldest entry is overwritten first. Starts empty after reset.
module pf_collapse_buf #(
    parameter int DEPTH = 32,
    parameter int AW    = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] query,
    output logic          hit,
    input  logic          ins,
    input  logic [AW-1:0] ins_addr
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0]    ent_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] eq;
    logic [PW-1:0]    wp_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = vld_q[g] && (ent_q[g] == query);
    end
    assign hit = |eq;

    // Round-robin write of issued lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            wp_q  <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (ins) begin
            ent_q[wp_q] <= ins_addr;
            vld_q[wp_q] <= 1'b1;
            wp_q        <= (int'(wp_q) == DEPTH - 1) ? '0 : wp_q + 1'b1;
        end
    end
endmodule

// File: rtl/delta_prefetch_detector.sv
// Delta pattern prefetch detector (top).
// Captures a trigger and its history window, bins by region, sorts, forms
// deltas, searches for a recurring tail or a doubling stride, and issues the
// predicted lines one at a time through a collapsing buffer.
// Assumes hist_addr/hist_valid are valid in the cycle trig_valid is taken.
module delta_prefetch_detector #(
    parameter int AW         = 26,
    parameter int HIST_N     = 16,
    parameter int REGION_LSB = 10,
    parameter int CB_DEPTH   = 32,
    parameter int GEN_AHEAD  = 4,
    parameter int EXP_AHEAD  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_valid,
    input  logic [AW-1:0]        trig_addr,
    input  logic [HIST_N*AW-1:0] hist_addr,
    input  logic [HIST_N-1:0]    hist_valid,
    output logic                 busy,
    output logic                 pf_valid,
    input  logic                 pf_ready,
    output logic [AW-1:0]        pf_addr
);
    import pf_pkg::*;

    localparam int S    = HIST_N + 1;
    localparam int KW   = AW + 1;
    localparam int IW   = $clog2(S + 1);
    localparam int DP   = 2 ** IW;
    localparam int RW   = AW - REGION_LSB;
    localparam int MAXA = (GEN_AHEAD > EXP_AHEAD) ? GEN_AHEAD : EXP_AHEAD;
    localparam int AHW  = $clog2(MAXA + 1);

    pf_state_e        state_q;
    pf_mode_e         mode_q;
    logic [AW-1:0]    raw_a [S];
    logic [S-1:0]     raw_v;
    logic [RW-1:0]    region_q;
    logic [IW-1:0]    pass_q, last_q, j_q, best_len_q, best_j_q, ridx_q, rst_idx_q;
    logic [AW-1:0]    d_q [DP];
    logic [AW-1:0]    top_q, acc_q;
    logic [AW:0]      e_q;
    logic [AHW-1:0]   k_q, ahead_q;
    logic             gone_q;

    logic [S*KW-1:0]  load_keys, sorted;
    logic [KW-1:0]    sk [S];
    logic [IW-1:0]    n_c, len_c, fin_len, fin_j;
    logic [AW-1:0]    top_c;
    logic [AW-1:0]    dlt_c [DP];
    logic [DP*AW-1:0] d_flat;
    logic             exp_c, gen_c;
    logic [AW:0]      step_c;
    logic [AW+1:0]    cand_c;
    logic             out_c, skip_c, adv_c, cb_hit;

    // Sort keys: entries outside the region or invalid get the top bit set.
    always_comb begin
        for (int i = 0; i < S; i++) begin
            load_keys[i*KW +: KW] =
                {~(raw_v[i] && (raw_a[i][AW-1:REGION_LSB] == region_q)), raw_a[i]};
        end
    end

    pf_sort_net #(.S(S), .W(KW)) u_sort (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == ST_LOAD),
        .load_keys (load_keys),
        .step      (state_q == ST_SORT),
        .odd       (pass_q[0]),
        .keys      (sorted)
    );

    for (genvar g = 0; g < S; g++) begin : g_sk
        assign sk[g] = sorted[g*KW +: KW];
    end

    // Count binned entries, pick the highest, and form neighbour deltas.
    always_comb begin
        n_c   = '0;
        top_c = '0;
        for (int i = 0; i < S; i++) if (!sk[i][KW-1]) n_c = n_c + 1'b1;
        for (int i = 0; i < S; i++) if (IW'(i) == n_c - 1'b1) top_c = sk[i][AW-1:0];
        for (int i = 0; i < DP; i++) dlt_c[i] = '0;
        for (int i = 0; i + 1 < S; i++) dlt_c[i] = sk[i+1][AW-1:0] - sk[i][AW-1:0];
    end

    for (genvar g = 0; g < DP; g++) begin : g_dflat
        assign d_flat[g*AW +: AW] = d_q[g];
    end

    pf_suffix_match #(.DP(DP), .AW(AW), .IW(IW)) u_match (
        .deltas (d_flat),
        .last_i (last_q),
        .j_i    (j_q),
        .len    (len_c)
    );

    // True when y lies within one of twice x.
    function automatic logic near_double(input logic [AW-1:0] x, input logic [AW-1:0] y);
        logic [AW+1:0] tx, yy;
        tx = {1'b0, x, 1'b0};
        yy = {2'b00, y};
        return ((yy + 1'b1) >= tx) && (yy <= (tx + 1'b1));
    endfunction

    // Final mode decision inputs for the last match cycle.
    always_comb begin
        fin_len = (len_c > best_len_q) ? len_c : best_len_q;
        fin_j   = (len_c > best_len_q) ? j_q   : best_j_q;
        gen_c   = (fin_len != '0);
        exp_c   = (d_q[last_q - 2'd2] != '0)
                && near_double(d_q[last_q - 2'd2], d_q[last_q - 1'b1])
                && near_double(d_q[last_q - 1'b1], d_q[last_q]);
    end

    // Candidate of the current issue step and its filtering.
    always_comb begin
        step_c = (mode_q == MODE_GEN) ? {1'b0, d_q[ridx_q]} : e_q;
        cand_c = {2'b00, acc_q} + {1'b0, step_c};
        out_c  = (cand_c[AW+1:AW] != 2'b00) || (cand_c[AW-1:REGION_LSB] != region_q);
        skip_c = out_c || gone_q || cb_hit;
        adv_c  = (state_q == ST_ISSUE) && (skip_c || pf_ready);
    end

    assign busy     = (state_q != ST_IDLE);
    assign pf_valid = (state_q == ST_ISSUE) && !skip_c;
    assign pf_addr  = cand_c[AW-1:0];

    pf_collapse_buf #(.DEPTH(CB_DEPTH), .AW(AW)) u_cbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .query    (cand_c[AW-1:0]),
        .hit      (cb_hit),
        .ins      (pf_valid && pf_ready),
        .ins_addr (cand_c[AW-1:0])
    );

    // Control state machine and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            mode_q     <= MODE_NONE;
            raw_v      <= '0;
            region_q   <= '0;
            pass_q     <= '0;
            last_q     <= '0;
            j_q        <= '0;
            best_len_q <= '0;
            best_j_q   <= '0;
            ridx_q     <= '0;
            rst_idx_q  <= '0;
            top_q      <= '0;
            acc_q      <= '0;
            e_q        <= '0;
            k_q        <= '0;
            ahead_q    <= '0;
            gone_q     <= 1'b0;
            for (int i = 0; i < S; i++) raw_a[i] <= '0;
            for (int i = 0; i < DP; i++) d_q[i] <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (trig_valid) begin
                    raw_a[0] <= trig_addr;
                    raw_v[0] <= 1'b1;
                    for (int i = 0; i < HIST_N; i++) begin
                        raw_a[i+1] <= hist_addr[i*AW +: AW];
                        raw_v[i+1] <= hist_valid[i];
                    end
                    region_q <= trig_addr[AW-1:REGION_LSB];
                    state_q  <= ST_LOAD;
                end
                ST_LOAD: begin
                    pass_q  <= '0;
                    state_q <= ST_SORT;
                end
                ST_SORT: begin
                    pass_q <= pass_q + 1'b1;
                    if (int'(pass_q) == S - 1) state_q <= ST_DELTA;
                end
                ST_DELTA: begin
                    for (int i = 0; i < DP; i++) d_q[i] <= dlt_c[i];
                    top_q      <= top_c;
                    last_q     <= n_c - 2'd2;
                    j_q        <= n_c - 2'd3;
                    best_len_q <= '0;
                    best_j_q   <= '0;
                    state_q    <= (n_c < 4) ? ST_IDLE : ST_MATCH;
                end
                ST_MATCH: begin
                    if (len_c > best_len_q) begin
                        best_len_q <= len_c;
                        best_j_q   <= j_q;
                    end
                    if (j_q != '0) begin
                        j_q <= j_q - 1'b1;
                    end else begin
                        acc_q     <= top_q;
                        k_q       <= '0;
                        gone_q    <= 1'b0;
                        ridx_q    <= fin_j + 1'b1;
                        rst_idx_q <= fin_j + 1'b1;
                        e_q       <= {d_q[last_q], 1'b0};
                        if (gen_c) begin
                            mode_q  <= MODE_GEN;
                            ahead_q <= AHW'(GEN_AHEAD);
                            state_q <= ST_ISSUE;
                        end else if (exp_c) begin
                            mode_q  <= MODE_EXP;
                            ahead_q <= AHW'(EXP_AHEAD);
                            state_q <= ST_ISSUE;
                        end else begin
                            mode_q  <= MODE_NONE;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_ISSUE: if (adv_c) begin
                    acc_q  <= cand_c[AW-1:0];
                    gone_q <= gone_q || out_c;
                    e_q    <= {e_q[AW-1:0], 1'b0};
                    ridx_q <= (ridx_q == last_q) ? rst_idx_q : ridx_q + 1'b1;
                    k_q    <= k_q + 1'b1;
                    if (k_q == ahead_q - 1'b1) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pf_detector_checks.sv
// Protocol and ordering properties of the prefetch detector, bound to the top.
module pf_detector_checks #(
    parameter int AW         = 26,
    parameter int REGION_LSB = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   trig_valid,
    input logic                   busy,
    input logic                   pf_valid,
    input logic                   pf_ready,
    input logic [AW-1:0]          pf_addr,
    input logic [AW-REGION_LSB-1:0] region_q
);
    a_r9_valid_only_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> busy);

    a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

    a_r6_issue_inside_region: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[AW-1:REGION_LSB] == region_q));

    a_r9_busy_ignores_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(region_q));

    a_r9_busy_after_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trig_valid) |=> busy);
endmodule

bind delta_prefetch_detector pf_detector_checks #(.AW(AW), .REGION_LSB(REGION_LSB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .busy       (busy),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr),
    .region_q   (region_q)
);

// File: tb/delta_prefetch_detector_tb.sv
`timescale 1ns/1ps
// Directed bench for the delta pattern prefetch detector.
module delta_prefetch_detector_tb;
    localparam int AW = 26;
    localparam int HN = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              trig_valid;
    logic [AW-1:0]     trig_addr;
    logic [HN*AW-1:0]  hist_addr;
    logic [HN-1:0]     hist_valid;
    logic              busy, pf_valid, pf_ready;
    logic [AW-1:0]     pf_addr;

    logic [AW-1:0]     h_arr [HN];
    logic [AW-1:0]     exp_q [$];
    logic [AW-1:0]     got_q [$];
    logic [AW-1:0]     stall_q [$];
    logic              first_busy;
    int                n_chk = 0;
    int                n_fail = 0;

    always #10 clk = ~clk;

    delta_prefetch_detector u_dut (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_addr(trig_addr),
        .hist_addr(hist_addr), .hist_valid(hist_valid), .busy(busy),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    always_comb for (int i = 0; i < HN; i++) hist_addr[i*AW +: AW] = h_arr[i];

    function automatic logic [AW-1:0] ra(input int region, input int off);
        return (AW'(region) << 10) + AW'(off);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic clear_hist();
        hist_valid = '0;
        for (int i = 0; i < HN; i++) h_arr[i] = '0;
        exp_q.delete();
    endtask

    task automatic put(input int idx, input logic [AW-1:0] a);
        h_arr[idx] = a;
        hist_valid[idx] = 1'b1;
    endtask

    // Fires a trigger and collects all accepted prefetches until idle.
    task automatic fire(input logic [AW-1:0] t, input bit noise, input int hold);
        int cyc;
        got_q.delete();
        stall_q.delete();
        @(negedge clk);
        trig_valid = 1'b1;
        trig_addr  = t;
        @(negedge clk);
        first_busy = busy;
        if (noise) trig_addr = ra(63, 0);
        else trig_valid = 1'b0;
        cyc = 0;
        while (busy && cyc < 3000) begin
            if (cyc == 3) trig_valid = 1'b0;
            if (cyc == hold) pf_ready = 1'b1;
            if (pf_valid && !pf_ready) stall_q.push_back(pf_addr);
            if (pf_valid && pf_ready) got_q.push_back(pf_addr);
            @(negedge clk);
            cyc++;
        end
        trig_valid = 1'b0;
        pf_ready   = 1'b1;
        if (cyc >= 3000) begin
            n_chk++; n_fail++;
            $display("FAIL R9 run did not return to idle: actual busy expected idle");
        end
    endtask

    task automatic compare(input string req);
        check(got_q.size() == exp_q.size(), req, "prefetch count",
              AW'(got_q.size()), AW'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(got_q[i] == exp_q[i], req, $sformatf("prefetch %0d", i), got_q[i], exp_q[i]);
    endtask

    // Stride-1 run in a region: lines 0..4 plus trigger 5, predicting 6..9.
    task automatic stride_run(input int region, input bit emits, input string req);
        clear_hist();
        for (int i = 0; i < 5; i++) put(i, ra(region, i));
        if (emits) for (int i = 6; i < 10; i++) exp_q.push_back(ra(region, i));
        fire(ra(region, 5), 1'b0, 0);
        compare(req);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R10", "busy after reset", AW'(busy), '0);
        check(pf_valid == 1'b0, "R10", "pf_valid after reset", AW'(pf_valid), '0);
    endtask

    task automatic t_stride();
        stride_run(1, 1'b1, "R4");
    endtask

    task automatic t_out_of_order();
        clear_hist();
        put(0, ra(2, 0)); put(1, ra(2, 1)); put(2, ra(2, 3));
        put(3, ra(2, 2)); put(4, ra(2, 6)); put(5, ra(2, 5));
        for (int i = 7; i < 11; i++) exp_q.push_back(ra(2, i));
        fire(ra(2, 4), 1'b0, 0);
        compare("R2");
    endtask

    task automatic t_region_bin();
        clear_hist();
        put(0, ra(3, 0)); put(1, ra(3, 2)); put(2, ra(4, 3));
        put(3, ra(3, 4)); put(4, ra(3, 6)); put(5, ra(3, 0) - 1);
        put(6, ra(4, 9));
        h_arr[7] = ra(3, 5);
        for (int i = 10; i < 18; i += 2) exp_q.push_back(ra(3, i));
        fire(ra(3, 8), 1'b0, 0);
        compare("R1");
    endtask

    task automatic t_repeat();
        clear_hist();
        put(0, ra(5, 6)); put(1, ra(5, 0)); put(2, ra(5, 4));
        put(3, ra(5, 1)); put(4, ra(5, 3));
        exp_q.push_back(ra(5, 9));  exp_q.push_back(ra(5, 10));
        exp_q.push_back(ra(5, 12)); exp_q.push_back(ra(5, 13));
        fire(ra(5, 7), 1'b0, 0);
        compare("R4");
    endtask

    task automatic t_exponential();
        clear_hist();
        put(0, ra(6, 0)); put(1, ra(6, 6)); put(2, ra(6, 19)); put(3, ra(6, 45));
        exp_q.push_back(ra(6, 201)); exp_q.push_back(ra(6, 409));
        fire(ra(6, 97), 1'b0, 0);
        compare("R5");
    endtask

    task automatic t_priority();
        clear_hist();
        put(0, ra(7, 0)); put(1, ra(7, 1)); put(2, ra(7, 3));
        put(3, ra(7, 7)); put(4, ra(7, 8)); put(5, ra(7, 10));
        exp_q.push_back(ra(7, 15)); exp_q.push_back(ra(7, 17));
        exp_q.push_back(ra(7, 21)); exp_q.push_back(ra(7, 22));
        fire(ra(7, 14), 1'b0, 0);
        compare("R5 generic priority");
    endtask

    task automatic t_edge();
        clear_hist();
        for (int i = 0; i < 4; i++) put(i, ra(8, 1018 + i));
        exp_q.push_back(ra(8, 1023));
        fire(ra(8, 1022), 1'b0, 0);
        compare("R6");
    endtask

    task automatic t_short();
        clear_hist();
        put(0, ra(9, 0)); put(1, ra(9, 1));
        fire(ra(9, 2), 1'b0, 0);
        compare("R3 two deltas");
        clear_hist();
        put(0, ra(10, 0)); put(1, ra(10, 1)); put(2, ra(10, 2));
        for (int i = 4; i < 8; i++) exp_q.push_back(ra(10, i));
        fire(ra(10, 3), 1'b0, 0);
        compare("R3 three deltas");
        clear_hist();
        put(0, ra(11, 0)); put(1, ra(11, 5)); put(2, ra(11, 6));
        fire(ra(11, 15), 1'b0, 0);
        compare("R4 no pattern");
    endtask

    task automatic t_busy();
        clear_hist();
        for (int i = 0; i < 5; i++) put(i, ra(12, i));
        for (int i = 6; i < 10; i++) exp_q.push_back(ra(12, i));
        fire(ra(12, 5), 1'b1, 0);
        check(first_busy == 1'b1, "R9", "busy after trigger", AW'(first_busy), 1);
        compare("R9 trigger while busy");
    endtask

    task automatic t_stall();
        clear_hist();
        for (int i = 0; i < 5; i++) put(i, ra(13, i));
        for (int i = 6; i < 10; i++) exp_q.push_back(ra(13, i));
        pf_ready = 1'b0;
        fire(ra(13, 5), 1'b0, 50);
        check(stall_q.size() >= 3, "R8", "stalled cycles seen", AW'(stall_q.size()), 3);
        for (int i = 0; i < stall_q.size(); i++)
            check(stall_q[i] == ra(13, 6), "R8", "held address", stall_q[i], ra(13, 6));
        compare("R8");
    endtask

    task automatic t_collapse();
        stride_run(40, 1'b1, "R7 first");
        stride_run(40, 1'b0, "R7 duplicate dropped");
        for (int r = 41; r < 48; r++) stride_run(r, 1'b1, "R7 fill");
        stride_run(40, 1'b0, "R7 still held");
        stride_run(48, 1'b1, "R7 fill");
        stride_run(40, 1'b1, "R7 oldest replaced");
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; trig_valid = 1'b0; trig_addr = '0; pf_ready = 1'b1;
        clear_hist();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stride();
        t_out_of_order();
        t_region_bin();
        t_repeat();
        t_exponential();
        t_priority();
        t_edge();
        t_short();
        t_busy();
        t_stall();
        t_collapse();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule